// File: doc/BRIEF.md
# Exception Entry and Status Controller

This block owns the processor's live status word and one saved copy of it for each of the five exception modes. Every cycle it picks at most one action: taking an exception, returning from an exception, a software write of the status word, or a branch-exchange that switches between the 32-bit and the 16-bit compact instruction state. A taken exception or a state change is announced with a one-cycle redirect carrying the next fetch address. An exception entry also carries a link write holding the address to return to.

A two-state machine drives the sequencing. ST_BOOT is entered by reset. Its single transition, BOOT_TO_RUN, fires on the first clock after reset is released and issues the reset vector. ST_RUN then stays in place (RUN_HOLD) and performs one action per cycle. The action is ACT_TRAP, ACT_RETURN, ACT_WRITE, ACT_BRANCH or ACT_IDLE. All results are registered, so they appear one clock after the request.

Top module: `xstat_ctrl`

## Requirements
- R1: While reset is held, the status word reads 0x000000D3. That value means supervisor mode, T=0, I=1, F=1 and all flags 0. On the first clock after reset is released, redirect pulses with next_pc 0x00. Status bit positions are N=31, Z=30, C=29, V=28, I=7, F=6, T=5 and mode=[4:0].
- R2: When several exception sources are active in one cycle, only the highest-priority one is taken. The order is reset, abort, fast interrupt, interrupt, undefined, software.
- R3: irq_line is ignored while I=1. fiq_line is ignored while F=1.
- R4: A taken exception copies the old status word into the saved register of the target mode. It then sets the new mode, clears T and sets I. F is set only for a reset or fast-interrupt entry; otherwise F keeps its old value. The mode codes are user 10000, fast 10001, interrupt 10010, supervisor 10011, abort 10111, undefined 11011 and system 11111. Reset and software exceptions enter supervisor mode.
- R5: The vector offsets are reset 0x00, undefined 0x04, software 0x08, abort 0x10, interrupt 0x18 and fast interrupt 0x1C.
- R6: Every taken exception pulses link_we, with link_val equal to pc_in from the request cycle.
- R7: A return in an exception mode copies that mode's saved word back into the status word. This includes T. It also redirects to pc_in.
- R8: A return in user or system mode pulses unpred. It leaves the status word unchanged and produces no redirect.
- R9: In user mode, a status write changes only bits [31:28]. Bits [27:0] are kept.
- R10: In any other mode, a status write replaces the whole word.
- R11: A branch-exchange redirects to the target with bit 0 cleared and sets T to bit 0 of the target.
- R12: An exception beats every other action in the same cycle, and the other actions are discarded. When no exception is taken, return beats status write, and status write beats branch-exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_req_i | input | 4 | Synchronous exception requests: bit0 reset, bit1 abort, bit2 undefined, bit3 software |
| irq_line_i | input | 1 | Normal interrupt line |
| fiq_line_i | input | 1 | Fast interrupt line |
| pc_in_i | input | PC_W | Return address for a link on entry; target of a return |
| ret_req_i | input | 1 | Exception return request |
| sw_req_i | input | 1 | Status write request |
| sw_data_i | input | 32 | Status write data |
| bx_req_i | input | 1 | Branch-exchange request |
| bx_target_i | input | PC_W | Branch-exchange target |
| status_o | output | 32 | Current status word |
| mode_o | output | 5 | Current mode code |
| thumb_o | output | 1 | Compact instruction state (T) |
| irq_mask_o | output | 1 | I bit |
| fiq_mask_o | output | 1 | F bit |
| link_we_o | output | 1 | Link write strobe |
| link_val_o | output | PC_W | Value to write into the link register |
| redirect_o | output | 1 | Next-PC valid strobe |
| next_pc_o | output | PC_W | Next fetch address |
| unpred_o | output | 1 | Saved-status access in a mode that has none |

## Verification
Exception entry can fall in the same cycle as a branch-exchange, a return or a status write. The bench provokes each case by raising an exception request together with that other request. A branch-exchange to an odd target, issued alongside a software exception, must give vector 0x08 and T=0. The T=1 state from before the entry must be restored by the following return. A return raised together with a status write in user mode must yield only the unpredictable pulse and leave the flags untouched.

// File: rtl/xstat_pkg.sv
package xstat_pkg;

    localparam int SW_W  = 32;
    localparam int NBANK = 5;
    localparam int NSRC  = 6;
    localparam int BIT_I = 7;
    localparam int BIT_F = 6;
    localparam int BIT_T = 5;

    // source index order is also priority order (0 highest)
    localparam int SRC_RST = 0;
    localparam int SRC_ABT = 1;
    localparam int SRC_FIQ = 2;
    localparam int SRC_IRQ = 3;
    localparam int SRC_UND = 4;
    localparam int SRC_SWI = 5;

    typedef enum logic [4:0] {
        M_USR = 5'b10000,
        M_FIQ = 5'b10001,
        M_IRQ = 5'b10010,
        M_SVC = 5'b10011,
        M_ABT = 5'b10111,
        M_UND = 5'b11011,
        M_SYS = 5'b11111
    } mode_e;

    typedef enum logic {ST_BOOT, ST_RUN} fsm_e;

    typedef enum logic [2:0] {
        ACT_IDLE, ACT_TRAP, ACT_RETURN, ACT_WRITE, ACT_BRANCH
    } act_e;

    function automatic logic bank_has(input logic [4:0] m);
        return (m == M_FIQ) || (m == M_IRQ) || (m == M_SVC) ||
               (m == M_ABT) || (m == M_UND);
    endfunction

    function automatic logic [2:0] bank_idx(input logic [4:0] m);
        logic [2:0] r;
        unique case (m)
            M_FIQ:   r = 3'd0;
            M_IRQ:   r = 3'd1;
            M_SVC:   r = 3'd2;
            M_ABT:   r = 3'd3;
            M_UND:   r = 3'd4;
            default: r = 3'd0;
        endcase
        return r;
    endfunction

    function automatic logic [4:0] src_mode(input int s);
        logic [4:0] r;
        unique case (s)
            SRC_ABT: r = M_ABT;
            SRC_FIQ: r = M_FIQ;
            SRC_IRQ: r = M_IRQ;
            SRC_UND: r = M_UND;
            default: r = M_SVC;
        endcase
        return r;
    endfunction

    function automatic logic [7:0] src_vec(input int s);
        logic [7:0] r;
        unique case (s)
            SRC_ABT: r = 8'h10;
            SRC_FIQ: r = 8'h1C;
            SRC_IRQ: r = 8'h18;
            SRC_UND: r = 8'h04;
            SRC_SWI: r = 8'h08;
            default: r = 8'h00;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/xstat_arb.sv
module xstat_arb #(
    parameter int N = 6
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    logic found;

    always_comb begin
        grant = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    assign any = |req;

endmodule

// File: rtl/xstat_bank.sv
module xstat_bank #(
    parameter int W  = 32,
    parameter int N  = 5,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_data
);
    logic [N-1:0][W-1:0] slot_w;

    for (genvar g = 0; g < N; g++) begin : g_slot
        logic [W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en && (int'(wr_idx) == g))
                q <= wr_data;
        end
        assign slot_w[g] = q;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N; i++)
            if (int'(rd_idx) == i) rd_data = slot_w[i];
    end

endmodule

// File: rtl/xstat_ctrl.sv
module xstat_ctrl
    import xstat_pkg::*;
#(
    parameter int          PC_W     = 32,
    parameter logic [31:0] VEC_BASE = 32'h0000_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      exc_req_i,
    input  logic            irq_line_i,
    input  logic            fiq_line_i,
    input  logic [PC_W-1:0] pc_in_i,
    input  logic            ret_req_i,
    input  logic            sw_req_i,
    input  logic [31:0]     sw_data_i,
    input  logic            bx_req_i,
    input  logic [PC_W-1:0] bx_target_i,
    output logic [31:0]     status_o,
    output logic [4:0]      mode_o,
    output logic            thumb_o,
    output logic            irq_mask_o,
    output logic            fiq_mask_o,
    output logic            link_we_o,
    output logic [PC_W-1:0] link_val_o,
    output logic            redirect_o,
    output logic [PC_W-1:0] next_pc_o,
    output logic            unpred_o
);
    localparam int          IW       = $clog2(NBANK);
    localparam logic [31:0] RST_WORD = {24'h0, 1'b1, 1'b1, 1'b0, M_SVC};

    fsm_e              state_q;
    logic [SW_W-1:0]   status_q, status_d;
    logic [NSRC-1:0]   src, grant;
    logic              trap_any;
    act_e              act;
    logic [4:0]        tmode;
    logic [7:0]        tvec;
    logic              tset_f;
    logic [SW_W-1:0]   saved_rd;
    logic              priv;

    // priority order follows the SRC_* indices
    always_comb begin
        src          = '0;
        src[SRC_RST] = exc_req_i[0];
        src[SRC_ABT] = exc_req_i[1];
        src[SRC_FIQ] = fiq_line_i && !status_q[BIT_F];
        src[SRC_IRQ] = irq_line_i && !status_q[BIT_I];
        src[SRC_UND] = exc_req_i[2];
        src[SRC_SWI] = exc_req_i[3];
    end

    xstat_arb #(.N(NSRC)) u_arb (
        .req   (src),
        .grant (grant),
        .any   (trap_any)
    );

    always_comb begin
        tmode  = M_SVC;
        tvec   = 8'h00;
        tset_f = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (grant[i]) begin
                tmode  = src_mode(i);
                tvec   = src_vec(i);
                tset_f = (i == SRC_RST) || (i == SRC_FIQ);
            end
        end
    end

    always_comb begin
        if (state_q == ST_BOOT) act = ACT_IDLE;
        else if (trap_any)      act = ACT_TRAP;
        else if (ret_req_i)     act = ACT_RETURN;
        else if (sw_req_i)      act = ACT_WRITE;
        else if (bx_req_i)      act = ACT_BRANCH;
        else                    act = ACT_IDLE;
    end

    assign priv = (status_q[4:0] != M_USR);

    xstat_bank #(.W(SW_W), .N(NBANK), .IW(IW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (act == ACT_TRAP),
        .wr_idx  (bank_idx(tmode)),
        .wr_data (status_q),
        .rd_idx  (bank_idx(status_q[4:0])),
        .rd_data (saved_rd)
    );

    always_comb begin
        status_d = status_q;
        unique case (act)
            ACT_TRAP:   status_d = {status_q[31:8], 1'b1,
                                    tset_f | status_q[BIT_F], 1'b0, tmode};
            ACT_RETURN: if (bank_has(status_q[4:0])) status_d = saved_rd;
            ACT_WRITE:  status_d = priv ? sw_data_i
                                        : {sw_data_i[31:28], status_q[27:0]};
            ACT_BRANCH: status_d[BIT_T] = bx_target_i[0];
            ACT_IDLE:   status_d = status_q;
        endcase
    end

    // state register: BOOT_TO_RUN, then RUN_HOLD
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_BOOT;
            status_q <= RST_WORD;
        end else begin
            state_q  <= ST_RUN;
            status_q <= status_d;
        end
    end

    // registered strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            redirect_o <= 1'b0;
            next_pc_o  <= '0;
            link_we_o  <= 1'b0;
            link_val_o <= '0;
            unpred_o   <= 1'b0;
        end else begin
            redirect_o <= 1'b0;
            link_we_o  <= 1'b0;
            unpred_o   <= 1'b0;
            if (state_q == ST_BOOT) begin
                redirect_o <= 1'b1;
                next_pc_o  <= PC_W'(VEC_BASE);
            end
            unique case (act)
                ACT_TRAP: begin
                    redirect_o <= 1'b1;
                    next_pc_o  <= PC_W'(VEC_BASE) + PC_W'(tvec);
                    link_we_o  <= 1'b1;
                    link_val_o <= pc_in_i;
                end
                ACT_RETURN: begin
                    if (bank_has(status_q[4:0])) begin
                        redirect_o <= 1'b1;
                        next_pc_o  <= pc_in_i;
                    end else begin
                        unpred_o   <= 1'b1;
                    end
                end
                ACT_BRANCH: begin
                    redirect_o <= 1'b1;
                    next_pc_o  <= {bx_target_i[PC_W-1:1], 1'b0};
                end
                ACT_WRITE, ACT_IDLE: ;
            endcase
        end
    end

    assign status_o   = status_q;
    assign mode_o     = status_q[4:0];
    assign thumb_o    = status_q[BIT_T];
    assign irq_mask_o = status_q[BIT_I];
    assign fiq_mask_o = status_q[BIT_F];

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R2
    AST_TRAP_CLEARS_T: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_TRAP |=> !thumb_o && irq_mask_o); // R4
    AST_LINK_ON_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_TRAP |=> link_we_o && link_val_o == $past(pc_in_i)); // R6
    AST_UNPRED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        unpred_o |-> $stable(status_o) && !redirect_o); // R8
    AST_USER_CTRL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_WRITE && mode_o == M_USR) |=>
            status_o[27:0] == $past(status_o[27:0])); // R9
    AST_BX_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_BRANCH |=> redirect_o && !next_pc_o[0] &&
            thumb_o == $past(bx_target_i[0])); // R11

endmodule

// File: tb/test_xstat_ctrl.sv
module test_xstat_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  exc_req = '0;
    logic        irq_line = 1'b0, fiq_line = 1'b0;
    logic [31:0] pc_in = '0;
    logic        ret_req = 1'b0, sw_req = 1'b0, bx_req = 1'b0;
    logic [31:0] sw_data = '0, bx_target = '0;
    logic [31:0] status;
    logic [4:0]  mode;
    logic        thumb, irq_mask, fiq_mask, link_we, redirect, unpred;
    logic [31:0] link_val, next_pc;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    xstat_ctrl i_xstat_ctrl (
        .clk(clk), .rst_n(rst_n), .exc_req_i(exc_req),
        .irq_line_i(irq_line), .fiq_line_i(fiq_line), .pc_in_i(pc_in),
        .ret_req_i(ret_req), .sw_req_i(sw_req), .sw_data_i(sw_data),
        .bx_req_i(bx_req), .bx_target_i(bx_target),
        .status_o(status), .mode_o(mode), .thumb_o(thumb),
        .irq_mask_o(irq_mask), .fiq_mask_o(fiq_mask),
        .link_we_o(link_we), .link_val_o(link_val),
        .redirect_o(redirect), .next_pc_o(next_pc), .unpred_o(unpred)
    );

    typedef struct {
        logic        redir;
        logic [31:0] npc;
        logic        lwe;
        logic [31:0] lval;
        logic        unp;
        logic [31:0] st;
        string       tag;
    } exp_t;

    exp_t        q[$];
    logic [31:0] m_st = 32'h0000_00D3;
    logic [31:0] m_bank[5];
    bit          m_boot = 1'b1;

    function automatic int bidx(input logic [4:0] m);
        case (m)
            5'b10001: return 0;
            5'b10010: return 1;
            5'b10011: return 2;
            5'b10111: return 3;
            5'b11011: return 4;
            default:  return -1;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
        end
    endtask

    // driver: called at a falling edge, drives one cycle and pushes expectation
    task automatic op(input logic [3:0] x, input logic il, input logic fl,
                      input logic rt, input logic wr, input logic [31:0] wd,
                      input logic bx, input logic [31:0] bt,
                      input logic [31:0] pc, input string tag);
        exp_t e;
        logic [5:0] src;
        int sel;
        logic [4:0] tm;
        logic [7:0] tv;
        logic fs;
        exc_req = x; irq_line = il; fiq_line = fl; ret_req = rt;
        sw_req = wr; sw_data = wd; bx_req = bx; bx_target = bt; pc_in = pc;
        e.redir = 0; e.npc = 'x; e.lwe = 0; e.lval = 'x; e.unp = 0; e.tag = tag;
        if (m_boot) begin
            e.redir = 1; e.npc = 32'h0; m_boot = 0;
        end else begin
            src = {x[3], x[2], il & ~m_st[7], fl & ~m_st[6], x[1], x[0]};
            sel = -1;
            for (int i = 0; i < 6; i++) if (src[i] && sel < 0) sel = i;
            if (sel >= 0) begin
                case (sel)
                    0: begin tm = 5'b10011; tv = 8'h00; fs = 1; end
                    1: begin tm = 5'b10111; tv = 8'h10; fs = 0; end
                    2: begin tm = 5'b10001; tv = 8'h1C; fs = 1; end
                    3: begin tm = 5'b10010; tv = 8'h18; fs = 0; end
                    4: begin tm = 5'b11011; tv = 8'h04; fs = 0; end
                    default: begin tm = 5'b10011; tv = 8'h08; fs = 0; end
                endcase
                m_bank[bidx(tm)] = m_st;
                m_st = {m_st[31:8], 1'b1, fs | m_st[6], 1'b0, tm};
                e.redir = 1; e.npc = {24'h0, tv}; e.lwe = 1; e.lval = pc;
            end else if (rt) begin
                if (bidx(m_st[4:0]) >= 0) begin
                    m_st = m_bank[bidx(m_st[4:0])];
                    e.redir = 1; e.npc = pc;
                end else e.unp = 1;
            end else if (wr) begin
                m_st = (m_st[4:0] == 5'b10000) ? {wd[31:28], m_st[27:0]} : wd;
            end else if (bx) begin
                m_st[5] = bt[0];
                e.redir = 1; e.npc = {bt[31:1], 1'b0};
            end
        end
        e.st = m_st;
        q.push_back(e);
        @(negedge clk);
    endtask

    // monitor: compares one result per cycle, just after the rising edge
    initial forever begin
        @(posedge clk);
        #1;
        if (q.size() > 0) begin
            exp_t e;
            bit ok;
            e = q.pop_front();
            ok = (redirect === e.redir) && (!e.redir || next_pc === e.npc) &&
                 (link_we === e.lwe) && (!e.lwe || link_val === e.lval) &&
                 (unpred === e.unp) && (status === e.st);
            check(ok, e.tag, "status", status, e.st);
            if (!ok)
                $display("     redirect=%0b/%0b npc=%08h/%08h lwe=%0b/%0b unpred=%0b/%0b",
                         redirect, e.redir, next_pc, e.npc, link_we, e.lwe, unpred, e.unp);
        end
    end

    task automatic report;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(status === 32'h0000_00D3 && redirect === 1'b0, "R1", "reset", status, 32'hD3);
        check(mode === 5'b10011 && irq_mask && fiq_mask && !thumb, "R1", "reset mode",
              {27'h0, mode}, 32'h13);
        rst_n = 1'b1;
        op(4'h0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 boot vector");
        op(4'h0, 0, 0, 0, 1, 32'h0000_0013, 0, 0, 0, "R10 privileged write");
        op(4'h0, 1, 0, 0, 0, 0, 0, 0, 32'h100, "R3 R4 R5 R6 irq entry");
        op(4'h0, 1, 0, 0, 0, 0, 0, 0, 32'h104, "R3 irq masked");
        op(4'h0, 0, 1, 0, 0, 0, 0, 0, 32'h200, "R4 R5 fiq entry sets F");
        op(4'h0, 0, 0, 1, 0, 0, 0, 0, 32'h204, "R7 return from fiq");
        op(4'h0, 0, 0, 1, 0, 0, 0, 0, 32'h108, "R7 return from irq");
        op(4'b1110, 1, 0, 0, 0, 0, 0, 0, 32'h300, "R2 abort beats und swi irq");
        op(4'h0, 0, 0, 1, 0, 0, 0, 0, 32'h304, "R7 return from abort");
        op(4'h0, 0, 0, 0, 0, 0, 1, 32'h0000_1001, 0, "R11 bx to compact");
        op(4'b1000, 0, 0, 0, 0, 0, 1, 32'h0000_2001, 32'h1002, "R12 swi beats bx");
        op(4'h0, 0, 0, 1, 0, 0, 0, 0, 32'h1004, "R7 return restores T");
        op(4'h0, 0, 0, 0, 0, 0, 1, 32'h0000_2000, 0, "R11 bx to 32-bit");
        op(4'h0, 0, 0, 1, 1, 32'h0000_001F, 1, 32'h5, 32'h400, "R12 return beats write bx");
        op(4'h0, 0, 0, 0, 1, 32'h0000_001F, 1, 32'h5, 0, "R12 write beats bx");
        op(4'h0, 0, 0, 1, 0, 0, 0, 0, 32'h500, "R8 return in system");
        op(4'h0, 0, 0, 0, 1, 32'hA000_0010, 0, 0, 0, "R10 write to user");
        op(4'h0, 0, 0, 0, 1, 32'hF000_00D3, 0, 0, 0, "R9 user write flags only");
        op(4'h0, 0, 0, 1, 1, 32'h0000_00D3, 0, 0, 32'h600, "R8 R12 return in user");
        op(4'h0, 1, 1, 0, 0, 0, 0, 0, 32'h700, "R2 fiq beats irq");
        op(4'b0001, 0, 1, 0, 0, 0, 0, 0, 32'h800, "R2 R5 reset request");
        op(4'b0100, 0, 0, 0, 0, 0, 0, 0, 32'h900, "R5 undefined entry");
        op(4'h0, 0, 0, 1, 0, 0, 0, 0, 32'h904, "R7 return from undefined");
        op(4'h0, 0, 0, 0, 0, 0, 0, 0, 0, "R12 idle");
        repeat (2) @(negedge clk);
        report();
    end

endmodule